// File: doc/BRIEF.md
# Stereo Sample Byte Packer for Flash

This block sits between an audio capture stream and a byte-wide flash device. Each accepted sample is one 32-bit word holding a 16-bit left channel in its upper half and a 16-bit right channel in its lower half. The block breaks every word into four byte programs, left channel first. The bytes go to consecutive flash addresses that start at zero.

The flash is divided into 1 KB blocks, and a block must be erased before any byte in it is programmed. Whenever the next byte address falls on a block boundary, the packer first sends a block-erase sequence and waits for the device to report ready. Each byte program is sent in three phases on a strobed 8-bit bus: an opcode byte, then the address bytes, then the data byte. After that the packer waits for the ready/busy line again. While a sample is being written, the sample input is not ready. When every byte of the device has been written, a sticky full flag rises and no more samples are accepted.

The device bus is write-only. A phase-kind output tells the device whether the current byte is an opcode, an address byte or a data byte.

Top module: `stereo_flash_packer`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, `in_ready` is 1, `full` is 0 and `fl_we` is 0. Reset also clears `full` and sets the byte address back to zero.
- R2: A sample is taken on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until all four of its bytes have been programmed and the flash has reported ready.
- R3: The four bytes of a sample go out in this order: `in_data[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. They are written to byte addresses a, a+1, a+2 and a+3.
- R4: Byte addresses begin at 0 after reset and go up by exactly one for each programmed byte, with no gaps.
- R5: A byte program is made of the following strobes, in this order:
  - an opcode strobe carrying 0x10, with `fl_kind` = 0;
  - ceil(ADDR_W/8) address strobes with `fl_kind` = 1, least significant address byte first;
  - one data strobe with `fl_kind` = 2.
- R6: If the low 10 bits of the next byte address are zero, the byte program is preceded by a block erase. The erase is an opcode strobe carrying 0x60, then the address bytes of that block base (least significant first), then a wait for ready. Each block is therefore erased exactly once, before its first byte.
- R7: After the last strobe of an erase or of a program, no further strobe is issued until `fl_rdy` is seen high. The device must lower `fl_rdy` on the clock edge that captures that last strobe.
- R8: Once 2^ADDR_W bytes have been written, `full` goes to 1 and stays there until reset. While `full` is 1, `in_ready` is 0, and a waiting `in_valid` causes no strobe.
- R9: `in_ready` is never 1 while `full` is 1 or while a strobe is on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be accepted |
| in_data | input | 32 | Stereo sample: left in [31:16], right in [15:0] |
| fl_we | output | 1 | One-cycle strobe marking a valid byte on `fl_bus` |
| fl_kind | output | 2 | Phase of the strobed byte: 0 opcode, 1 address, 2 data |
| fl_bus | output | 8 | Byte sent to the flash |
| fl_rdy | input | 1 | Flash ready (1) or busy (0) |
| full | output | 1 | Every byte of the device has been written |

## Verification
The embedded assertions check the following on every cycle:
- the address counter steps by one and the full flag stays set once it rises;
- the state is held while the device is busy;
- a program opcode at a block start comes only straight after an erase wait;
- a data strobe follows only the address phase;
- the input is never ready while the block is full or strobing.

Other behaviours only show up through the bench's flash model, which starts with every byte at 0x00:
- the byte order inside each word;
- little-endian address assembly;
- erasure of each block before its first program;
- the erase count;
- refusal of input once the device is full.

// File: rtl/packer_pkg.sv
package packer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ECMD,
    ST_EADR,
    ST_EWAIT,
    ST_PCMD,
    ST_PADR,
    ST_PDAT,
    ST_PWAIT
  } pk_state_e;

  typedef enum logic [1:0] {
    FK_CMD  = 2'd0,
    FK_ADDR = 2'd1,
    FK_DATA = 2'd2
  } fl_kind_e;

  localparam logic [7:0] OP_PROGRAM = 8'h10;
  localparam logic [7:0] OP_ERASE   = 8'h60;

endpackage

// File: rtl/packer_rst_sync.sv
module packer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_core_n <= stage_q;
    end
  end
endmodule

// File: rtl/packer_addr_ctr.sv
module packer_addr_ctr #(
  parameter int ADDR_W     = 25,
  parameter int BLOCK_BITS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr,
  output logic              full,
  output logic              blk_start
);
  logic [ADDR_W:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign cnt_en = inc && !cnt_q[ADDR_W];

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign addr      = cnt_q[ADDR_W-1:0];
  assign full      = cnt_q[ADDR_W];
  assign blk_start = (cnt_q[BLOCK_BITS-1:0] == '0);

  assert_full_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !full) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/packer_lane_mux.sv
module packer_lane_mux #(
  parameter int SAMPLE_W = 32,
  localparam int LANES   = SAMPLE_W / 8,
  localparam int LANE_W  = $clog2(LANES)
) (
  input  logic [SAMPLE_W-1:0] word,
  input  logic [LANE_W-1:0]   lane,
  output logic [7:0]          lane_byte
);
  logic [7:0] slice [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_slice
      assign slice[g] = word[SAMPLE_W-1-8*g -: 8];
    end
  endgenerate

  assign lane_byte = slice[lane];
endmodule

// File: rtl/packer_seq.sv
module packer_seq
  import packer_pkg::*;
#(
  parameter int ADDR_W    = 25,
  parameter int SAMPLE_W  = 32,
  localparam int LANES    = SAMPLE_W / 8,
  localparam int LANE_W   = $clog2(LANES),
  localparam int ADR_BYTES = (ADDR_W + 7) / 8,
  localparam int ADR_CW   = (ADR_BYTES > 1) ? $clog2(ADR_BYTES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                in_ready,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                full,
  input  logic                blk_start,
  output logic                byte_inc,
  output logic [SAMPLE_W-1:0] word_q,
  output logic [LANE_W-1:0]   lane_q,
  input  logic [7:0]          lane_byte,
  input  logic                fl_rdy,
  output logic                fl_we,
  output logic [1:0]          fl_kind,
  output logic [7:0]          fl_bus
);
  pk_state_e state_q, state_d;
  logic [ADR_CW-1:0] acnt_q, acnt_d;
  logic [LANE_W-1:0] lane_d;
  logic              take;
  logic              adr_last;
  logic [ADR_BYTES*8-1:0] addr_pad;

  assign addr_pad = {{(ADR_BYTES*8-ADDR_W){1'b0}}, addr};
  assign adr_last = (acnt_q == ADR_CW'(ADR_BYTES - 1));
  assign in_ready = (state_q == ST_IDLE) && !full;
  assign take     = in_valid && in_ready;
  assign byte_inc = (state_q == ST_PDAT);

  always_comb begin
    state_d = state_q;
    acnt_d  = acnt_q;
    lane_d  = lane_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          lane_d  = '0;
          state_d = blk_start ? ST_ECMD : ST_PCMD;
        end
      end
      ST_ECMD: begin
        acnt_d  = '0;
        state_d = ST_EADR;
      end
      ST_EADR: begin
        if (adr_last) state_d = ST_EWAIT;
        else          acnt_d  = acnt_q + 1'b1;
      end
      ST_EWAIT: begin
        if (fl_rdy) state_d = ST_PCMD;
      end
      ST_PCMD: begin
        acnt_d  = '0;
        state_d = ST_PADR;
      end
      ST_PADR: begin
        if (adr_last) state_d = ST_PDAT;
        else          acnt_d  = acnt_q + 1'b1;
      end
      ST_PDAT: begin
        state_d = ST_PWAIT;
      end
      ST_PWAIT: begin
        if (fl_rdy) begin
          if (lane_q == LANE_W'(LANES - 1)) begin
            state_d = ST_IDLE;
          end else begin
            lane_d  = lane_q + 1'b1;
            state_d = blk_start ? ST_ECMD : ST_PCMD;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      acnt_q  <= '0;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      acnt_q  <= acnt_d;
      lane_q  <= lane_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (take) begin
      word_q <= in_data;
    end
  end

  always_comb begin
    fl_we   = 1'b0;
    fl_kind = FK_CMD;
    fl_bus  = '0;
    unique case (state_q)
      ST_ECMD: begin
        fl_we  = 1'b1;
        fl_bus = OP_ERASE;
      end
      ST_PCMD: begin
        fl_we  = 1'b1;
        fl_bus = OP_PROGRAM;
      end
      ST_EADR, ST_PADR: begin
        fl_we   = 1'b1;
        fl_kind = FK_ADDR;
        fl_bus  = addr_pad[8*acnt_q +: 8];
      end
      ST_PDAT: begin
        fl_we   = 1'b1;
        fl_kind = FK_DATA;
        fl_bus  = lane_byte;
      end
      default: ;
    endcase
  end

  assert_erase_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PCMD && blk_start) |-> ($past(state_q) == ST_EWAIT));

  assert_wait_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_EWAIT || state_q == ST_PWAIT) && !fl_rdy) |=> (state_q == $past(state_q)));

  assert_data_after_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PDAT) |-> ($past(state_q) == ST_PADR));

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!full && !fl_we));
endmodule

// File: rtl/stereo_flash_packer.sv
module stereo_flash_packer #(
  parameter int ADDR_W     = 25,
  parameter int BLOCK_BITS = 10,
  parameter int SAMPLE_W   = 32,
  localparam int LANE_W    = $clog2(SAMPLE_W / 8)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                fl_we,
  output logic [1:0]          fl_kind,
  output logic [7:0]          fl_bus,
  input  logic                fl_rdy,
  output logic                full
);
  logic                rst_core_n;
  logic                byte_inc;
  logic                blk_start;
  logic [ADDR_W-1:0]   addr;
  logic [SAMPLE_W-1:0] word_q;
  logic [LANE_W-1:0]   lane_q;
  logic [7:0]          lane_byte;

  packer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  packer_addr_ctr #(.ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS)) u_addr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .inc       (byte_inc),
    .addr      (addr),
    .full      (full),
    .blk_start (blk_start)
  );

  packer_lane_mux #(.SAMPLE_W(SAMPLE_W)) u_lane (
    .word      (word_q),
    .lane      (lane_q),
    .lane_byte (lane_byte)
  );

  packer_seq #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .addr      (addr),
    .full      (full),
    .blk_start (blk_start),
    .byte_inc  (byte_inc),
    .word_q    (word_q),
    .lane_q    (lane_q),
    .lane_byte (lane_byte),
    .fl_rdy    (fl_rdy),
    .fl_we     (fl_we),
    .fl_kind   (fl_kind),
    .fl_bus    (fl_bus)
  );
endmodule

// File: tb/stereo_flash_packer_tb_top.sv
`timescale 1ns/1ps
module stereo_flash_packer_tb_top;
  localparam int AW     = 11;
  localparam int MEM_N  = 1 << AW;
  localparam int NSAMP  = MEM_N / 4;
  localparam int ADRB   = (AW + 7) / 8;
  localparam int BUSY_N = 3;
  localparam int WD     = 150000;

  localparam logic [31:0] VEC [8] = '{
    32'h1234_5678, 32'hFFFF_0000, 32'h0000_FFFF, 32'hA5A5_5A5A,
    32'h8001_7FFE, 32'hDEAD_BEEF, 32'h0102_0304, 32'hFF00_00FF
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        fl_we;
  logic [1:0]  fl_kind;
  logic [7:0]  fl_bus;
  logic        fl_rdy;
  logic        full;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  stereo_flash_packer #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .fl_we(fl_we), .fl_kind(fl_kind), .fl_bus(fl_bus),
    .fl_rdy(fl_rdy), .full(full)
  );

  // flash model
  logic [7:0]  mem [MEM_N];
  logic [7:0]  op;
  logic [15:0] aval;
  logic [15:0] nv;
  int          acnt;
  int          busy = 0;
  bit          init_done = 1'b0;
  int erase_cnt = 0, wr_cnt = 0, prog_err = 0, proto_err = 0, erase_adr_err = 0;
  int ready_err = 0, we_seen = 0;

  assign fl_rdy = (busy == 0);

  always @(posedge clk) begin
    if (!init_done) begin
      for (int k = 0; k < MEM_N; k++) mem[k] <= 8'h00;
      init_done <= 1'b1;
    end
    if (busy != 0) busy <= busy - 1;
    if (fl_we) begin
      if (busy != 0) proto_err <= proto_err + 1;
      case (fl_kind)
        2'd0: begin op <= fl_bus; acnt <= 0; aval <= '0; end
        2'd1: begin
          nv = aval | (16'(fl_bus) << (8 * acnt));
          aval <= nv;
          acnt <= acnt + 1;
          if (op == 8'h60 && acnt == ADRB - 1) begin
            if (nv[9:0] != 10'd0) erase_adr_err <= erase_adr_err + 1;
            for (int j = 0; j < 1024; j++) mem[(int'(nv[AW-1:0]) + j) % MEM_N] <= 8'hFF;
            erase_cnt <= erase_cnt + 1;
            busy <= BUSY_N;
          end
        end
        2'd2: begin
          if (op != 8'h10 || acnt != ADRB) proto_err <= proto_err + 1;
          else begin
            if (mem[aval[AW-1:0]] != 8'hFF) prog_err <= prog_err + 1;
            mem[aval[AW-1:0]] <= fl_bus;
            wr_cnt <= wr_cnt + 1;
            busy <= BUSY_N;
          end
        end
        default: proto_err <= proto_err + 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (in_ready && (fl_we || !fl_rdy)) ready_err <= ready_err + 1;
    if (fl_we) we_seen <= we_seen + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R2 in_ready low after accept", 32'(in_ready), 0);
    while (!(in_ready || full)) @(negedge clk);
  endtask

  task automatic check_word(input int idx, input logic [31:0] w, input string tag);
    logic [31:0] got;
    got = {mem[4*idx], mem[4*idx+1], mem[4*idx+2], mem[4*idx+3]};
    check(got == w, tag, got, w);
  endtask

  function automatic logic [31:0] gen(input int i);
    return {16'(i) ^ 16'hA5C3, ~16'(i * 7)};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && full == 1'b0 && fl_we == 1'b0, "R1 outputs in reset",
          {29'd0, in_ready, full, fl_we}, 32'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1 && full == 1'b0 && fl_we == 1'b0, "R1 outputs after release",
          {29'd0, in_ready, full, fl_we}, 32'h4);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    do_reset();

    // table walk: R3 byte order and R4 sequential addresses from zero
    for (int i = 0; i < 8; i++) begin
      send(VEC[i]);
      check_word(i, VEC[i], "R3 R4 table word bytes");
    end
    check(erase_cnt == 1, "R6 one erase for first block", erase_cnt, 1);
    check(wr_cnt == 32, "R4 bytes written after table", wr_cnt, 32);

    // fill the rest: crossing into the second block and up to capacity
    for (int i = 8; i < NSAMP; i++) begin
      send(gen(i));
      check_word(i, gen(i), "R3 generated word bytes");
      if (i == 255) check(erase_cnt == 1, "R6 no erase before boundary", erase_cnt, 1);
      if (i == 256) check(erase_cnt == 2, "R6 erase at 1KB boundary", erase_cnt, 2);
    end
    check(erase_adr_err == 0, "R6 erase address block aligned", erase_adr_err, 0);
    check(prog_err == 0, "R6 every byte programmed only after erase", prog_err, 0);
    check(proto_err == 0, "R5 R7 strobe order and busy wait", proto_err, 0);
    check(ready_err == 0, "R2 R9 in_ready quiet while busy", ready_err, 0);
    check(wr_cnt == MEM_N, "R4 total bytes written", wr_cnt, MEM_N);

    // R8 full and refusal
    @(negedge clk);
    check(full == 1'b1, "R8 full at capacity", 32'(full), 1);
    check(in_ready == 1'b0, "R8 R9 in_ready low when full", 32'(in_ready), 0);
    begin
      int we0;
      int wr0;
      we0 = we_seen;
      wr0 = wr_cnt;
      in_valid = 1'b1;
      in_data  = 32'hCAFE_F00D;
      repeat (20) @(negedge clk);
      in_valid = 1'b0;
      check(we_seen == we0, "R8 no strobe when full", we_seen, we0);
      check(wr_cnt == wr0, "R8 no byte written when full", wr_cnt, wr0);
      check(full == 1'b1, "R8 full stays set", 32'(full), 1);
    end

    // R1 reset clears full and restarts at address zero
    do_reset();
    send(32'h5566_7788);
    check_word(0, 32'h5566_7788, "R1 R4 restart at address zero");
    check(erase_cnt == 3, "R6 block zero erased again after reset", erase_cnt, 3);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule